// File: doc/BRIEF.md
# Multiplexed Digit Scanner with PWM Brightness

This block lights a common-cathode seven-segment display of up to eight digits, one digit at a time. A position counter walks through the enabled digits. For the digit in focus it raises that digit's select line and drives eight segment lines, so that persistence of vision shows the whole display. The scan moves only on a one-cycle `tick` strobe, which a divider elsewhere in the chip supplies.

Each digit slot lasts 17 ticks. The first tick is a dark gap that stops ghosting between neighbouring digits. The next 16 ticks form a PWM window, and in that window the digit's own 4-bit brightness code sets how many ticks carry the pattern. The pattern is either the raw byte from the digit's register or a glyph decoded from its low nibble. Decoding is chosen per digit, and one shared selector picks the decimal-style font or the hexadecimal font. Register values arrive as flat buses from the register file. The outputs are derived without a register stage from the scan state and those buses.

Top module: `led_scan_mux`

## Requirements
- R1: After reset, digit 0 is in focus at the gap tick: `dig_sel` is 8'h01 and `seg` is 8'h00.
- R2: With `scan_limit` = n, the focus runs 0, 1, ..., n and then returns to 0. No digit above n is ever selected, and `dig_sel` is one-hot.
- R3: A slot lasts 17 ticks: one gap tick, then PWM steps 0 to 15. State changes only on cycles where `tick` is high.
- R4: During the gap tick `seg` is 8'h00 while the digit select stays active.
- R5: With brightness code k (the digit's nibble in `intensity`, digit i at bits 4i+3:4i), the pattern is shown on PWM steps 0 to k for k ≤ 14, which is (k+1) of 16 steps. Code 15 also shows it on 15 steps (0 to 14).
- R6: When decoding is off for a digit (`decode_en` bit i = 0), `seg` equals the raw byte: bit 7 is the decimal point, bits 6 to 0 are segments a to g, and bit 0 is g.
- R7: Decimal font (`hex_font` = 0): codes 0 to 9 give the digits, 0xA gives a dash (g only, 8'h01), 0xB E (8'h4F), 0xC H (8'h37), 0xD L (8'h0E), 0xE P (8'h67), and 0xF a blank (8'h00).
- R8: Hex font (`hex_font` = 1): codes 0xA to 0xF give A (8'h77), b (8'h1F), C (8'h4E), d (8'h3D), E (8'h4F) and F (8'h47). The digit glyphs are 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=5F, 7=70, 8=7F, 9=7B.
- R9: For a decoded digit, data bits 6:4 have no effect and data bit 7 drives `seg[7]` directly, with 1 meaning lit.
- R10: With `shutdown` high and `disp_test` low, both `seg` and `dig_sel` are all zero. Once `shutdown` falls, the earlier pattern returns unchanged.
- R11: With `disp_test` high, `seg` and `dig_sel` are all ones, whatever the shutdown state, scan limit or scan phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Scan advance strobe, one cycle wide |
| scan_limit | input | 3 | Index of the last digit scanned |
| decode_en | input | 8 | Per-digit decode enable (bit i for digit i) |
| hex_font | input | 1 | Font choice for decoded digits: 0 decimal, 1 hex |
| shutdown | input | 1 | Blank all outputs |
| disp_test | input | 1 | Light every segment and digit |
| digit_data | input | 64 | Digit bytes, digit i at bits 8i+7:8i |
| intensity | input | 32 | Brightness codes, digit i at bits 4i+3:4i |
| dig_sel | output | 8 | Digit select lines, active high |
| seg | output | 8 | Segment lines {dp,a,b,c,d,e,f,g}, active high |

## Verification
Scan position and PWM step are registers that move on the clock edge where `tick` is high. Any result that depends on position is therefore due in the cycle right after that edge. The bench raises `tick` for exactly one cycle, updates its own position model, and samples on the following falling edge. Font, raw mapping, shutdown and test-mode results pass through no register, so they are due in the same cycle as the input change. The bench changes those inputs on a falling edge and samples one cycle later, while the scan position is held still.

// File: rtl/scan_pkg.sv
package scan_pkg;
   localparam int SEG_W  = 8;
   localparam int CODE_W = 4;

   // Segment order in a 7-bit glyph: {a,b,c,d,e,f,g}
   function automatic logic [6:0] glyph(input logic [3:0] code, input logic hex);
      logic [6:0] g;
      case (code)
         4'h0: g = 7'h7E;
         4'h1: g = 7'h30;
         4'h2: g = 7'h6D;
         4'h3: g = 7'h79;
         4'h4: g = 7'h33;
         4'h5: g = 7'h5B;
         4'h6: g = 7'h5F;
         4'h7: g = 7'h70;
         4'h8: g = 7'h7F;
         4'h9: g = 7'h7B;
         4'hA: g = hex ? 7'h77 : 7'h01;
         4'hB: g = hex ? 7'h1F : 7'h4F;
         4'hC: g = hex ? 7'h4E : 7'h37;
         4'hD: g = hex ? 7'h3D : 7'h0E;
         4'hE: g = hex ? 7'h4F : 7'h67;
         default: g = hex ? 7'h47 : 7'h00;
      endcase
      return g;
   endfunction
endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
   parameter int NUM_DIGITS = 8,
   parameter int PWM_STEPS  = 16,
   localparam int IDX_W = $clog2(NUM_DIGITS),
   localparam int PH_W  = $clog2(PWM_STEPS + 1),
   localparam int STP_W = $clog2(PWM_STEPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [IDX_W-1:0] scan_limit,
   output logic [IDX_W-1:0] idx,
   output logic             gap,
   output logic [STP_W-1:0] pwm_step
);
   localparam logic [PH_W-1:0] LAST_PH = PH_W'(PWM_STEPS);

   logic [PH_W-1:0] phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx   <= '0;
         phase <= '0;
      end else if (tick) begin
         if (phase == LAST_PH) begin
            phase <= '0;
            idx   <= (idx >= scan_limit) ? '0 : idx + 1'b1;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end

   assign gap      = (phase == '0);
   assign pwm_step = STP_W'(phase - 1'b1);

   a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(idx) && $stable(phase)));
   a_r2_wrap_after_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && phase == LAST_PH && idx >= scan_limit) |=> (idx == '0 && phase == '0));
endmodule

// File: rtl/seg_pattern.sv
module seg_pattern
   import scan_pkg::*;
(
   input  logic [SEG_W-1:0] data,
   input  logic             decode,
   input  logic             hex_sel,
   output logic [SEG_W-1:0] pattern
);
   always_comb begin
      if (decode) pattern = {data[7], glyph(data[3:0], hex_sel)};
      else        pattern = data;
   end

   always_comb begin
      if (decode) a_r9_dp_passthru: assert (pattern[7] == data[7]);
   end
endmodule

// File: rtl/pwm_gate.sv
module pwm_gate #(
   parameter int CODE_W = 4,
   localparam int LIM_W = CODE_W + 1
) (
   input  logic [CODE_W-1:0] code,
   input  logic [CODE_W-1:0] step,
   input  logic              gap,
   output logic              on
);
   logic [LIM_W-1:0] limit;

   always_comb begin
      if (&code) limit = {1'b0, code};
      else       limit = {1'b0, code} + 1'b1;
      on = !gap && ({1'b0, step} < limit);
   end
endmodule

// File: rtl/led_scan_mux.sv
module led_scan_mux
   import scan_pkg::*;
#(
   parameter int NUM_DIGITS = 8,
   parameter int PWM_STEPS  = 16,
   localparam int IDX_W = $clog2(NUM_DIGITS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick,
   input  logic [IDX_W-1:0]           scan_limit,
   input  logic [NUM_DIGITS-1:0]      decode_en,
   input  logic                       hex_font,
   input  logic                       shutdown,
   input  logic                       disp_test,
   input  logic [NUM_DIGITS*SEG_W-1:0]  digit_data,
   input  logic [NUM_DIGITS*CODE_W-1:0] intensity,
   output logic [NUM_DIGITS-1:0]      dig_sel,
   output logic [SEG_W-1:0]           seg
);
   if (NUM_DIGITS < 2 || (1 << IDX_W) != NUM_DIGITS) begin : g_bad_digits
      $error("NUM_DIGITS must be a power of two of at least 2");
   end
   if (PWM_STEPS != (1 << CODE_W)) begin : g_bad_steps
      $error("PWM_STEPS must equal the number of brightness codes");
   end

   logic [SEG_W-1:0]  byte_of  [NUM_DIGITS];
   logic [CODE_W-1:0] level_of [NUM_DIGITS];

   for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_unpack
      assign byte_of[i]  = digit_data[i*SEG_W +: SEG_W];
      assign level_of[i] = intensity[i*CODE_W +: CODE_W];
   end

   logic [IDX_W-1:0]  idx;
   logic              gap;
   logic [CODE_W-1:0] step;
   logic [SEG_W-1:0]  pattern;
   logic              seg_on;

   scan_sequencer #(.NUM_DIGITS(NUM_DIGITS), .PWM_STEPS(PWM_STEPS)) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .scan_limit(scan_limit),
      .idx(idx), .gap(gap), .pwm_step(step)
   );

   seg_pattern u_pat (
      .data(byte_of[idx]), .decode(decode_en[idx]), .hex_sel(hex_font),
      .pattern(pattern)
   );

   pwm_gate #(.CODE_W(CODE_W)) u_pwm (
      .code(level_of[idx]), .step(step), .gap(gap), .on(seg_on)
   );

   always_comb begin
      if (disp_test) begin
         dig_sel = '1;
         seg     = '1;
      end else if (shutdown) begin
         dig_sel = '0;
         seg     = '0;
      end else begin
         dig_sel = NUM_DIGITS'(1) << idx;
         seg     = seg_on ? pattern : '0;
      end
   end

   a_r2_onehot_select: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_test |-> $onehot0(dig_sel));
   a_r4_gap_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (gap && !disp_test) |-> (seg == '0));
   a_r5_last_step_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (!gap && &step) |-> !seg_on);
   a_r10_shutdown_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (shutdown && !disp_test) |-> (seg == '0 && dig_sel == '0));
   a_r11_test_lit: assert property (@(posedge clk) disable iff (!rst_n)
      disp_test |-> (&seg && &dig_sel));
endmodule

// File: tb/led_scan_mux_bench.sv
module led_scan_mux_bench;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        tick = 0;
   logic [2:0]  scan_limit = 3'd7;
   logic [7:0]  decode_en = 8'h00;
   logic        hex_font = 0;
   logic        shutdown = 0;
   logic        disp_test = 0;
   logic [63:0] digit_data;
   logic [31:0] intensity;
   logic [7:0]  dig_sel, seg;

   logic [7:0] dbyte [8];
   logic [3:0] ival  [8];

   int checks = 0, fails = 0;
   int mdig = 0, mph = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   always_comb begin
      for (int i = 0; i < 8; i++) begin
         digit_data[i*8 +: 8] = dbyte[i];
         intensity[i*4 +: 4]  = ival[i];
      end
   end

   led_scan_mux u_led_scan_mux (
      .clk(clk), .rst_n(rst_n), .tick(tick), .scan_limit(scan_limit),
      .decode_en(decode_en), .hex_font(hex_font), .shutdown(shutdown),
      .disp_test(disp_test), .digit_data(digit_data), .intensity(intensity),
      .dig_sel(dig_sel), .seg(seg)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      if (mph == 16) begin
         mph  = 0;
         mdig = (mdig >= int'(scan_limit)) ? 0 : mdig + 1;
      end else mph++;
   endtask

   task automatic goto_pos(input int d, input int p);
      for (int n = 0; n < 400 && !(mdig == d && mph == p); n++) step();
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   function automatic logic [7:0] font(input logic [3:0] c, input bit hx);
      logic [6:0] g;
      case (c)
         4'h0: g = 7'h7E; 4'h1: g = 7'h30; 4'h2: g = 7'h6D; 4'h3: g = 7'h79;
         4'h4: g = 7'h33; 4'h5: g = 7'h5B; 4'h6: g = 7'h5F; 4'h7: g = 7'h70;
         4'h8: g = 7'h7F; 4'h9: g = 7'h7B;
         4'hA: g = hx ? 7'h77 : 7'h01; 4'hB: g = hx ? 7'h1F : 7'h4F;
         4'hC: g = hx ? 7'h4E : 7'h37; 4'hD: g = hx ? 7'h3D : 7'h0E;
         4'hE: g = hx ? 7'h4F : 7'h67; default: g = hx ? 7'h47 : 7'h00;
      endcase
      return {1'b0, g};
   endfunction

   task automatic t_reset();
      check("R1 dig_sel", dig_sel, 8'h01);
      check("R1 seg", seg, 8'h00);
   endtask

   task automatic t_scan();
      int bad = 0;
      scan_limit = 3'd2;
      for (int i = 0; i < 8; i++) begin dbyte[i] = 8'hFF; ival[i] = 4'hF; end
      goto_pos(0, 0);
      for (int n = 0; n < 17 * 7; n++) begin
         step();
         if (mph == 0) begin
            check("R2 select follows scan order", dig_sel, 8'(1) << mdig);
            check("R4 gap tick dark", seg, 8'h00);
         end
         if (mdig > 2 || (dig_sel & 8'hF8) != 0) bad++;
      end
      check("R2 no digit above limit", 8'(bad), 8'h00);
      // R3: one slot after gap of digit 1 focus moves to digit 2
      goto_pos(1, 0);
      for (int n = 0; n < 16; n++) step();
      check("R3 still digit 1 at step 15", dig_sel, 8'h02);
      step();
      check("R3 digit 2 after 17 ticks", dig_sel, 8'h04);
      tick = 0;
      repeat (3) @(negedge clk);
      check("R3 no move without tick", dig_sel, 8'h04);
   endtask

   task automatic t_pwm(input logic [3:0] k);
      int lit = 0;
      scan_limit = 3'd0;
      decode_en  = 8'h00;
      dbyte[0] = 8'hFF;
      ival[0]  = k;
      goto_pos(0, 0);
      for (int n = 0; n < 16; n++) begin
         step();
         if (seg == 8'hFF) lit++;
      end
      check($sformatf("R5 lit steps for code %0d", k), 8'(lit), (k == 4'hF) ? 8'd15 : 8'(k) + 8'd1);
   endtask

   task automatic t_raw();
      scan_limit = 3'd0; decode_en = 8'h00; ival[0] = 4'hF;
      goto_pos(0, 1);
      dbyte[0] = 8'hA5; settle();
      check("R6 raw byte A5", seg, 8'hA5);
      dbyte[0] = 8'h01; settle();
      check("R6 bit0 is segment g", seg, 8'h01);
   endtask

   task automatic t_font(input bit hx);
      scan_limit = 3'd0; decode_en = 8'h01; hex_font = hx; ival[0] = 4'hF;
      goto_pos(0, 1);
      for (int c = 0; c < 16; c++) begin
         dbyte[0] = 8'(c); settle();
         check(hx ? "R8 hex glyph" : "R7 decimal glyph", seg, font(4'(c), hx));
      end
      hex_font = 0;
   endtask

   task automatic t_dp();
      scan_limit = 3'd0; decode_en = 8'h01; hex_font = 0;
      goto_pos(0, 1);
      dbyte[0] = 8'h73; settle();
      check("R9 bits 6:4 ignored", seg, 8'h79);
      dbyte[0] = 8'h83; settle();
      check("R9 dp on", seg, 8'hF9);
   endtask

   task automatic t_shutdown();
      scan_limit = 3'd0; decode_en = 8'h00;
      goto_pos(0, 1);
      dbyte[0] = 8'h5A; settle();
      shutdown = 1; settle();
      check("R10 seg dark", seg, 8'h00);
      check("R10 dig dark", dig_sel, 8'h00);
      shutdown = 0; settle();
      check("R10 pattern retained", seg, 8'h5A);
   endtask

   task automatic t_test();
      scan_limit = 3'd0;
      goto_pos(0, 0);
      shutdown = 1; disp_test = 1; settle();
      check("R11 seg all on", seg, 8'hFF);
      check("R11 dig all on", dig_sel, 8'hFF);
      disp_test = 0; shutdown = 0; settle();
      check("R11 release to gap dark", seg, 8'h00);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin dbyte[i] = 8'h00; ival[i] = 4'h0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      settle();
      t_reset();
      t_scan();
      t_pwm(4'd0);
      t_pwm(4'd7);
      t_pwm(4'd14);
      t_pwm(4'd15);
      t_raw();
      t_font(0);
      t_font(1);
      t_dp();
      t_shutdown();
      t_test();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule